// File: doc/BRIEF.md
# In-Order Retire Control Unit

This block keeps track of the instructions that are in flight between dispatch and retirement in an out-of-order core. When an instruction is dispatched, it reserves a token made of one or more consecutive slots in a circular buffer of `DEPTH` slots. The number of slots comes from the instruction's micro-op count, and the token identifier that comes back is the position of the token's first slot. The execution units later report, by token identifier, that an instruction has written back.

In every cycle the unit looks at the oldest tokens. Starting at the head, it retires the ones marked executed, strictly in program order. It stops at the first token that is not executed and also stops at a per-cycle limit. The retired instruction indices appear on parallel retire lanes, and the retired slots go back to the free pool at the next clock edge. Full, empty and free-slot outputs let the dispatch stage decide whether to stall.

Top module: `rcu_retire_unit`

## Requirements
- R1: After reset the unit is empty: `empty_o`=1, `full_o`=0, `free_o`=DEPTH, `rsv_token_o`=0, and no retire lane is valid.
- R2: A reservation occupies max(1, min(uops, DEPTH)) slots. A micro-op count of 0 takes one slot, and a count above DEPTH takes the whole buffer.
- R3: `rsv_ready_o` is 1 exactly when the capped slot count is no more than `free_o`. A request made while it is 0 is ignored: the token and the free count stay unchanged.
- R4: `rsv_token_o` shows the first slot that the next token will take. After each accepted reservation it moves forward by that token's slot count, modulo DEPTH.
- R5: A token retires only after it has been marked executed. Retirement goes from the oldest token and stops at the first token that is not executed, even when younger tokens are already executed. Lane 0 always carries the oldest retiring instruction, and the valid lanes form a contiguous group that starts at lane 0.
- R6: No more than RETIRE_MAX tokens retire in one cycle. When RETIRE_MAX is 0 there is no limit, and every executed token in the leading run retires together.
- R7: An executed mark takes effect at the clock edge where it is sampled. The token can appear on a retire lane, with its instruction index, in the cycle right after that edge.
- R8: At each edge, `free_o` changes by the slots freed by this cycle's retirement minus the slots taken by this cycle's accepted reservation.
- R9: `full_o` is 1 exactly when no slot is free, and `empty_o` is 1 exactly when all DEPTH slots are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsv_valid_i | input | 1 | Reservation request |
| rsv_idx_i | input | IDX_W | Instruction index stored in the token |
| rsv_uops_i | input | UOP_W | Micro-op count of the instruction |
| rsv_ready_o | output | 1 | The request fits in the free slots |
| rsv_token_o | output | TOK_W | Token identifier that a request in this cycle receives |
| exe_valid_i | input | 1 | Executed notification |
| exe_token_i | input | TOK_W | Token that has finished execution |
| ret_valid_o | output | LANES | Per-lane retire valid, lane 0 oldest |
| ret_idx_o | output | LANES*IDX_W | Retired instruction indices, lane k in bits [k*IDX_W +: IDX_W] |
| full_o | output | 1 | No free slot |
| empty_o | output | 1 | All slots free |
| free_o | output | CNT_W | Number of free slots |

## Verification
The assertions and the design assume two things about the inputs. Executed notifications name only tokens that are live and not yet marked. No notification names a token in the same cycle that the token is reserved. The reference model in the bench picks each notification from its own list of live tokens that are not yet executed, and the tokens it reserves in a cycle are added only after that choice, so the stimulus never breaks these assumptions. Reservation requests are not restricted: oversized and zero counts are sent on purpose, and so are requests while the unit is full. Two instances are exercised, one with a limit of two retirements per cycle and one with no limit.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

  // Slots a request occupies: at least one, never more than the buffer.
  function automatic int unsigned cap_slots(input int unsigned uops,
                                            input int unsigned depth);
    if (uops == 0) return 1;
    if (uops > depth) return depth;
    return uops;
  endfunction

  // Circular advance; base < depth and step <= depth.
  function automatic int unsigned wrap_add(input int unsigned base,
                                           input int unsigned step,
                                           input int unsigned depth);
    int unsigned s;
    s = base + step;
    return (s >= depth) ? s - depth : s;
  endfunction

endpackage

// File: rtl/rcu_space_tracker.sv
module rcu_space_tracker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int TOK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [CNT_W-1:0] alloc_slots,
  input  logic [CNT_W-1:0] free_slots,
  output logic [TOK_W-1:0] head_o,
  output logic [TOK_W-1:0] tail_o,
  output logic [CNT_W-1:0] avail_o
);
  logic [TOK_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] avail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      avail_q <= CNT_W'(DEPTH);
    end else begin
      head_q <= TOK_W'(rcu_pkg::wrap_add(32'(head_q), 32'(free_slots), DEPTH));
      if (alloc_en)
        tail_q <= TOK_W'(rcu_pkg::wrap_add(32'(tail_q), 32'(alloc_slots), DEPTH));
      avail_q <= avail_q + free_slots - (alloc_en ? alloc_slots : '0);
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign avail_o = avail_q;
endmodule

// File: rtl/rcu_token_store.sv
module rcu_token_store #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 8,
  parameter int CNT_W = 5,
  parameter int TOK_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [TOK_W-1:0]            wr_ptr,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [CNT_W-1:0]            wr_slots,
  input  logic                        mark_en,
  input  logic [TOK_W-1:0]            mark_ptr,
  output logic [DEPTH-1:0][IDX_W-1:0] idx_o,
  output logic [DEPTH-1:0][CNT_W-1:0] slots_o,
  output logic [DEPTH-1:0]            done_o
);
  // One record per slot; only the first slot of a token carries meaning.
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        idx_o[s]   <= '0;
        slots_o[s] <= '0;
        done_o[s]  <= 1'b0;
      end else if (wr_en && wr_ptr == TOK_W'(s)) begin
        idx_o[s]   <= wr_idx;
        slots_o[s] <= wr_slots;
        done_o[s]  <= 1'b0;
      end else if (mark_en && mark_ptr == TOK_W'(s)) begin
        done_o[s]  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rcu_retire_select.sv
module rcu_retire_select #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 8,
  parameter int CNT_W = 5,
  parameter int TOK_W = 4,
  parameter int LANES = 2
) (
  input  logic [TOK_W-1:0]            head,
  input  logic [CNT_W-1:0]            used,
  input  logic [DEPTH-1:0][IDX_W-1:0] idx,
  input  logic [DEPTH-1:0][CNT_W-1:0] slots,
  input  logic [DEPTH-1:0]            done,
  output logic [LANES-1:0]            lane_valid,
  output logic [LANES-1:0][IDX_W-1:0] lane_idx,
  output logic [CNT_W-1:0]            freed
);
  logic [TOK_W-1:0] ptr [LANES];
  logic [CNT_W-1:0] acc [LANES+1];
  logic             go  [LANES];

  assign ptr[0] = head;
  assign acc[0] = '0;
  assign go[0]  = 1'b1;

  // Lane k looks at the token that follows the k older tokens before it.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_valid[k] = go[k] && (acc[k] < used) && done[ptr[k]];
    assign lane_idx[k]   = idx[ptr[k]];
    assign acc[k+1]      = acc[k] + (lane_valid[k] ? slots[ptr[k]] : '0);
    if (k + 1 < LANES) begin : g_next
      assign go[k+1]  = lane_valid[k];
      assign ptr[k+1] = TOK_W'(rcu_pkg::wrap_add(32'(ptr[k]), 32'(slots[ptr[k]]), DEPTH));
    end
  end

  assign freed = acc[LANES];
endmodule

// File: rtl/rcu_retire_unit.sv
module rcu_retire_unit #(
  parameter int DEPTH      = 16,
  parameter int IDX_W      = 8,
  parameter int UOP_W      = 6,
  parameter int RETIRE_MAX = 2,
  localparam int TOK_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int LANES = (RETIRE_MAX == 0 || RETIRE_MAX > DEPTH) ? DEPTH : RETIRE_MAX
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rsv_valid_i,
  input  logic [IDX_W-1:0]       rsv_idx_i,
  input  logic [UOP_W-1:0]       rsv_uops_i,
  output logic                   rsv_ready_o,
  output logic [TOK_W-1:0]       rsv_token_o,
  input  logic                   exe_valid_i,
  input  logic [TOK_W-1:0]       exe_token_i,
  output logic [LANES-1:0]       ret_valid_o,
  output logic [LANES*IDX_W-1:0] ret_idx_o,
  output logic                   full_o,
  output logic                   empty_o,
  output logic [CNT_W-1:0]       free_o
);
  // Named internal events, visible to the bound checker.
  logic [CNT_W-1:0]            rsv_slots;
  logic                        rsv_fire;
  logic [CNT_W-1:0]            freed_slots;
  logic [CNT_W-1:0]            used_slots;
  logic [TOK_W-1:0]            head, tail;
  logic [CNT_W-1:0]            avail;
  logic [DEPTH-1:0][IDX_W-1:0] st_idx;
  logic [DEPTH-1:0][CNT_W-1:0] st_slots;
  logic [DEPTH-1:0]            st_done;
  logic [LANES-1:0][IDX_W-1:0] lane_idx;

  assign rsv_slots   = CNT_W'(rcu_pkg::cap_slots(32'(rsv_uops_i), DEPTH));
  assign rsv_ready_o = (rsv_slots <= avail);
  assign rsv_fire    = rsv_valid_i && rsv_ready_o;
  assign rsv_token_o = tail;
  assign used_slots  = CNT_W'(DEPTH) - avail;

  rcu_space_tracker #(.DEPTH(DEPTH), .CNT_W(CNT_W), .TOK_W(TOK_W)) u_space (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (rsv_fire),
    .alloc_slots(rsv_slots),
    .free_slots (freed_slots),
    .head_o     (head),
    .tail_o     (tail),
    .avail_o    (avail)
  );

  rcu_token_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .TOK_W(TOK_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rsv_fire),
    .wr_ptr  (tail),
    .wr_idx  (rsv_idx_i),
    .wr_slots(rsv_slots),
    .mark_en (exe_valid_i),
    .mark_ptr(exe_token_i),
    .idx_o   (st_idx),
    .slots_o (st_slots),
    .done_o  (st_done)
  );

  rcu_retire_select #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .TOK_W(TOK_W),
                      .LANES(LANES)) u_select (
    .head      (head),
    .used      (used_slots),
    .idx       (st_idx),
    .slots     (st_slots),
    .done      (st_done),
    .lane_valid(ret_valid_o),
    .lane_idx  (lane_idx),
    .freed     (freed_slots)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_out
    assign ret_idx_o[k*IDX_W +: IDX_W] = lane_idx[k];
  end

  assign full_o  = (avail == '0);
  assign empty_o = (avail == CNT_W'(DEPTH));
  assign free_o  = avail;
endmodule

// File: rtl/rcu_retire_unit_sva.sv
module rcu_retire_unit_sva #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int TOK_W = 4,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rsv_valid_i,
  input logic             rsv_fire,
  input logic             rsv_ready_o,
  input logic [CNT_W-1:0] rsv_slots,
  input logic [TOK_W-1:0] rsv_token_o,
  input logic [CNT_W-1:0] free_o,
  input logic             full_o,
  input logic             empty_o,
  input logic [LANES-1:0] ret_valid_o,
  input logic [CNT_W-1:0] freed_slots
);
  // R2: capped slot count stays within 1..DEPTH
  p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_valid_i |-> (rsv_slots != '0 && rsv_slots <= CNT_W'(DEPTH)));

  // R3: an accepted reservation never takes more than is free
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_fire |-> (rsv_slots <= free_o));

  // R4: token pointer advances by the reserved slots
  p_token_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_fire |=> rsv_token_o ==
      TOK_W'(rcu_pkg::wrap_add(32'($past(rsv_token_o)), 32'($past(rsv_slots)), DEPTH)));

  // R5: retire lanes form a prefix starting at lane 0
  p_lane_prefix_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (LANES'(ret_valid_o + 1'b1) & ret_valid_o) == '0);

  // R5: nothing retires from an empty buffer
  p_empty_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> ret_valid_o == '0);

  // R8: free count follows reservations and retirements
  p_free_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_fire || freed_slots != '0 |=> free_o ==
      CNT_W'($past(free_o) + $past(freed_slots) - ($past(rsv_fire) ? $past(rsv_slots) : '0)));

  // R9: a full buffer refuses every request
  p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !rsv_ready_o && !empty_o);
endmodule

bind rcu_retire_unit rcu_retire_unit_sva #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .TOK_W(TOK_W), .LANES(LANES)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .rsv_valid_i(rsv_valid_i),
  .rsv_fire   (rsv_fire),
  .rsv_ready_o(rsv_ready_o),
  .rsv_slots  (rsv_slots),
  .rsv_token_o(rsv_token_o),
  .free_o     (free_o),
  .full_o     (full_o),
  .empty_o    (empty_o),
  .ret_valid_o(ret_valid_o),
  .freed_slots(freed_slots)
);

// File: tb/rcu_retire_unit_tb_top.sv
module rcu_retire_unit_tb_top;
  localparam int D  = 16;
  localparam int IW = 8;
  localparam int UW = 6;
  localparam int TW = 4;
  localparam int CW = 5;
  localparam int LA = 2;   // limited instance lanes
  localparam int LU = 16;  // unlimited instance lanes

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          sel = 1'b0;
  logic          rv = 1'b0, ev = 1'b0;
  logic [IW-1:0] ridx = '0;
  logic [UW-1:0] ruops = '0;
  logic [TW-1:0] etok = '0;

  logic a_ready, u_ready, a_full, u_full, a_empty, u_empty;
  logic [TW-1:0] a_tok, u_tok;
  logic [CW-1:0] a_free, u_free;
  logic [LA-1:0] a_rv;
  logic [LU-1:0] u_rv;
  logic [LA*IW-1:0] a_ridx;
  logic [LU*IW-1:0] u_ridx;

  rcu_retire_unit #(.DEPTH(D), .IDX_W(IW), .UOP_W(UW), .RETIRE_MAX(2)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rsv_valid_i(rv && !sel), .rsv_idx_i(ridx), .rsv_uops_i(ruops),
    .rsv_ready_o(a_ready), .rsv_token_o(a_tok),
    .exe_valid_i(ev && !sel), .exe_token_i(etok),
    .ret_valid_o(a_rv), .ret_idx_o(a_ridx),
    .full_o(a_full), .empty_o(a_empty), .free_o(a_free));

  rcu_retire_unit #(.DEPTH(D), .IDX_W(IW), .UOP_W(UW), .RETIRE_MAX(0)) dut_u (
    .clk(clk), .rst_n(rst_n),
    .rsv_valid_i(rv && sel), .rsv_idx_i(ridx), .rsv_uops_i(ruops),
    .rsv_ready_o(u_ready), .rsv_token_o(u_tok),
    .exe_valid_i(ev && sel), .exe_token_i(etok),
    .ret_valid_o(u_rv), .ret_idx_o(u_ridx),
    .full_o(u_full), .empty_o(u_empty), .free_o(u_free));

  // Outputs of the instance under test
  logic m_ready, m_full, m_empty;
  logic [TW-1:0] m_tok;
  logic [CW-1:0] m_free;
  logic [LU-1:0] m_rv;
  logic [LU*IW-1:0] m_ridx;
  always_comb begin
    m_ready = sel ? u_ready : a_ready;
    m_full  = sel ? u_full  : a_full;
    m_empty = sel ? u_empty : a_empty;
    m_tok   = sel ? u_tok   : a_tok;
    m_free  = sel ? u_free  : a_free;
    m_rv    = sel ? u_rv    : LU'(a_rv);
    m_ridx  = sel ? u_ridx  : (LU*IW)'(a_ridx);
  end

  // Behavioural reference model
  typedef struct { int idx; int slots; bit ex; int tok; } tk_t;
  tk_t q[$];
  int lim, free_m, tail_m, nxt_idx;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int capm(input int u);
    return (u == 0) ? 1 : (u > D ? D : u);
  endfunction

  function automatic int n_retire();
    int n = 0;
    while (n < q.size() && q[n].ex && (lim == 0 || n < lim)) n++;
    return n;
  endfunction

  task automatic step(input bit v, input int uops, input bit e, input int et);
    int s, n, fr;
    bit rdy;
    rv = v; ruops = UW'(uops); ridx = IW'(nxt_idx); ev = e; etok = TW'(et);
    #1;
    s = capm(uops);
    rdy = (s <= free_m);
    chk("R3 ready", int'(m_ready), int'(rdy));
    chk("R4 token", int'(m_tok), tail_m);
    chk("R8 free", int'(m_free), free_m);
    chk("R9 full", int'(m_full), int'(free_m == 0));
    chk("R9 empty", int'(m_empty), int'(free_m == D));
    n = n_retire();
    chk("R6 retire count", $countones(m_rv), n);
    for (int k = 0; k < LU; k++) begin
      chk("R5 lane valid", int'(m_rv[k]), int'(k < n));
      if (k < n) chk("R5 lane idx", int'(m_ridx[k*IW +: IW]), q[k].idx);
    end
    @(posedge clk);
    fr = 0;
    for (int k = 0; k < n; k++) fr += q[k].slots;
    for (int k = 0; k < n; k++) void'(q.pop_front());
    if (e) foreach (q[i]) if (q[i].tok == et) q[i].ex = 1'b1;
    free_m += fr;
    if (v && rdy) begin
      q.push_back('{idx: nxt_idx % 256, slots: s, ex: 1'b0, tok: tail_m});
      tail_m = (tail_m + s) % D;
      free_m -= s;
      nxt_idx++;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rv = 0; ev = 0;
    q.delete(); free_m = D; tail_m = 0; nxt_idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 free", int'(m_free), D);
    chk("R1 empty", int'(m_empty), 1);
    chk("R1 full", int'(m_full), 0);
    chk("R1 token", int'(m_tok), 0);
    chk("R1 no retire", int'(m_rv), 0);
  endtask

  function automatic int pick_exe();
    int c[$];
    foreach (q[i]) if (!q[i].ex) c.push_back(q[i].tok);
    if (c.size() == 0) return -1;
    return c[$urandom_range(c.size() - 1)];
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    for (int ph = 0; ph < 2; ph++) begin
      sel = (ph == 1);
      lim = (ph == 1) ? 0 : 2;
      @(negedge clk);
      do_reset();
      begin
        int t0, t1, ta, tb, tc, et;
        t0 = tail_m;
        step(1, 0, 0, 0);
        chk("R2 zero count takes one slot", int'(m_free), D - 1);
        step(1, 40, 0, 0);
        chk("R3 refused request leaves free", int'(m_free), D - 1);
        chk("R3 refused request leaves token", int'(m_tok), 1);
        step(0, 0, 1, t0);
        chk("R7 retire after mark", int'(m_rv[0]), 1);
        chk("R7 retire idx", int'(m_ridx[IW-1:0]), 0);
        idle(1);
        t1 = tail_m;
        step(1, 40, 0, 0);
        chk("R2 oversize capped to depth", int'(m_free), 0);
        chk("R9 full when no slot", int'(m_full), 1);
        step(1, 1, 1, t1);
        idle(2);
        ta = tail_m; step(1, 3, 0, 0);
        tb = tail_m; step(1, 2, 0, 0);
        tc = tail_m; step(1, 1, 0, 0);
        step(0, 0, 1, tc);
        step(0, 0, 1, tb);
        chk("R5 stop at oldest unexecuted", int'(m_rv), 0);
        step(0, 0, 1, ta);
        chk("R6 retire limit", $countones(m_rv), (lim == 0) ? 3 : 2);
        idle(3);
        for (int i = 0; i < 3000; i++) begin
          bit rq, ee;
          int u;
          rq = ((i % 200) < 170) && ($urandom_range(9) < 7);
          u = ($urandom_range(19) == 0) ? 63 : int'($urandom_range(20));
          et = pick_exe();
          ee = (et >= 0) && ($urandom_range(9) < (((i % 200) < 170) ? 5 : 9));
          step(rq, u, ee, ee ? et : 0);
        end
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule